// File: doc/BRIEF.md
# Two-Wire Bus Status Flag Unit

This block keeps the status flags of a two-wire serial bus controller that can run as bus master or as addressed slave. The bus engine feeds it single-cycle event strobes: start seen, stop issued or seen, repeated start with a matching or a foreign address, byte received, holding register moved into the shifter, shifter drained, ACK or NACK sampled, master enable and arbitration lost. Software accesses reach it as strobes for a transmit-holding write, a receive-holding read and a status-word read.

Each flag is a registered bit whose set and clear terms depend on the operating mode, on a pending NACK and on repeated-start address matching. Four further status bits are level indications from the engine, registered once. Every flag becomes visible on the status word one clock after the edge that samples its event. A NACK that is still standing while the transmitter is idle freezes the transmit path: further holding-register writes are dropped until software reads the status word.

Top module: `twb_status_flags`

## Requirements
- R1: After reset the whole status word reads 0, transmit-ready included.
- R2: In master mode (slave_mode=0) bit 0 (transfer done) clears on a start strobe and sets on a stop strobe only when no byte waits in the holding register and the shifter is empty; a stop with data still pending leaves it at 0.
- R3: In slave mode bit 0 clears on a start or on a repeated start with matching address, and sets on a stop or on a repeated start with a foreign address.
- R4: Bit 1 (receive ready) sets on a byte-received strobe and clears on a receive-holding read strobe.
- R5: Bit 6 (overrun) sets when a byte arrives while bit 1 is already 1, and clears on a status-word read strobe.
- R6: In master mode bit 2 (transmit ready) sets on the master-enable strobe and on a holding-to-shifter move, and clears on a transmit-holding write.
- R7: In master mode a NACK strobe makes bits 0, 2 and 8 all read 1 on the same following cycle.
- R8: In slave mode bit 2 clears on a transmit-holding write and stays 0 until an ACK or NACK strobe, after which it reads 1.
- R9: While bits 2 and 8 both read 1, a transmit-holding write is ignored: bit 2 stays 1 and no byte becomes pending.
- R10: Bit 8 (NACK) and bit 9 (arbitration lost) are sticky: set by their strobes, cleared by a status-word read strobe.
- R11: When a set and a clear term reach the same flag in one cycle, the flag ends at 1 (with SET_WINS=1).
- R12: Bits 3 (slave read), 4 (slave selected), 5 (general call) and 10 (clock stretching) copy their engine levels one cycle later; bit 7 and bits 11 up to STATUS_W-1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | 1 = slave operation, 0 = master operation |
| ev_start | input | 1 | Start condition strobe |
| ev_stop | input | 1 | Stop issued or detected strobe |
| ev_rs_match | input | 1 | Repeated start with own address strobe |
| ev_rs_miss | input | 1 | Repeated start with foreign address strobe |
| ev_byte_rx | input | 1 | Byte written into receive holding strobe |
| ev_hold_to_shift | input | 1 | Holding register moved to shifter strobe |
| ev_shift_empty | input | 1 | Shifter drained strobe |
| ev_ack | input | 1 | ACK sampled strobe |
| ev_nack | input | 1 | NACK sampled strobe |
| ev_enable | input | 1 | Master operation enabled strobe |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| lv_slv_rd | input | 1 | Slave read-direction level |
| lv_slv_sel | input | 1 | Slave addressed level |
| lv_gen_call | input | 1 | General call level |
| lv_clk_stretch | input | 1 | Clock held low level |
| sw_thr_wr | input | 1 | Software write of transmit holding register |
| sw_rhr_rd | input | 1 | Software read of receive holding register |
| sw_sr_rd | input | 1 | Software read of the status word |
| status | output | STATUS_W | Status word |

## Verification
The bench builds the block with STATUS_W=32 and SET_WINS=1, so the full word including the zero upper half is observed and the set-priority variant is the one exercised. With SET_WINS=1 the collisions of byte-received with receive read and of NACK with status read become directed cases, and random phases in both modes reach NACK freezes, stops with pending data and overrun chains that a reference model follows cycle by cycle.

// File: rtl/twb_status_pkg.sv
package twb_status_pkg;

   localparam int BIT_XFER_DONE   = 0;
   localparam int BIT_RX_AVAIL    = 1;
   localparam int BIT_TX_FREE     = 2;
   localparam int BIT_SLV_RD      = 3;
   localparam int BIT_SLV_SEL     = 4;
   localparam int BIT_GEN_CALL    = 5;
   localparam int BIT_RX_OVERRUN  = 6;
   localparam int BIT_NACK_SEEN   = 8;
   localparam int BIT_ARB_LOST    = 9;
   localparam int BIT_CLK_STRETCH = 10;
   localparam int MIN_WORD_W      = 11;
   localparam int NUM_LEVELS      = 4;

   typedef struct packed {
      logic clk_stretch;
      logic gen_call;
      logic slv_sel;
      logic slv_rd;
   } twb_levels_t;

endpackage

// File: rtl/twb_flag_cell.sv
module twb_flag_cell #(
   parameter bit SET_WINS = 1'b1,
   parameter bit RST_VAL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_prio
         always_comb begin
            if (set_i)      nxt = 1'b1;
            else if (clr_i) nxt = 1'b0;
            else            nxt = q_o;
         end
      end else begin : g_clr_prio
         always_comb begin
            if (clr_i)      nxt = 1'b0;
            else if (set_i) nxt = 1'b1;
            else            nxt = q_o;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= nxt;
   end

   generate
      if (SET_WINS) begin : g_chk
         p_set_prio_r11 : assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q_o);
      end
   endgenerate
endmodule

// File: rtl/twb_tx_track.sv
module twb_tx_track #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slave_mode,
   input  logic ev_start,
   input  logic ev_stop,
   input  logic ev_rs_match,
   input  logic ev_rs_miss,
   input  logic ev_hold_to_shift,
   input  logic ev_shift_empty,
   input  logic ev_ack,
   input  logic ev_nack,
   input  logic ev_enable,
   input  logic sw_thr_wr,
   input  logic nack_flag,
   output logic xfer_done,
   output logic tx_free
);
   logic hold_full, shift_busy;
   logic wr_ok, frozen;
   logic xd_set, xd_clr, tf_set, tf_clr;

   assign frozen = tx_free & nack_flag;
   assign wr_ok  = sw_thr_wr & ~frozen;

   twb_flag_cell #(.SET_WINS(SET_WINS), .RST_VAL(1'b0)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .set_i(wr_ok), .clr_i(ev_hold_to_shift | ev_nack), .q_o(hold_full));

   twb_flag_cell #(.SET_WINS(SET_WINS), .RST_VAL(1'b0)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .set_i(ev_hold_to_shift), .clr_i(ev_shift_empty | ev_nack), .q_o(shift_busy));

   always_comb begin
      if (slave_mode) begin
         xd_set = ev_stop | ev_rs_miss;
         xd_clr = ev_start | ev_rs_match;
         tf_set = ev_ack | ev_nack;
      end else begin
         xd_set = (ev_stop & ~hold_full & ~shift_busy) | ev_nack;
         xd_clr = ev_start;
         tf_set = ev_enable | ev_hold_to_shift | ev_nack;
      end
      tf_clr = wr_ok;
   end

   twb_flag_cell #(.SET_WINS(SET_WINS), .RST_VAL(1'b0)) u_xfer (
      .clk(clk), .rst_n(rst_n),
      .set_i(xd_set), .clr_i(xd_clr), .q_o(xfer_done));

   twb_flag_cell #(.SET_WINS(SET_WINS), .RST_VAL(1'b0)) u_free (
      .clk(clk), .rst_n(rst_n),
      .set_i(tf_set), .clr_i(tf_clr), .q_o(tx_free));

   p_master_done_cause_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(xfer_done) && !$past(slave_mode)) |-> $past(ev_stop || ev_nack));

   p_slave_done_set_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode && (ev_stop || ev_rs_miss)) |=> xfer_done);

   p_frozen_keeps_free_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_free && nack_flag) |=> tx_free);

   p_slave_free_wait_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode && $fell(tx_free)) |-> $past(sw_thr_wr));
endmodule

// File: rtl/twb_rx_track.sv
module twb_rx_track #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_byte_rx,
   input  logic sw_rhr_rd,
   input  logic sw_sr_rd,
   output logic rx_avail,
   output logic rx_overrun
);
   twb_flag_cell #(.SET_WINS(SET_WINS), .RST_VAL(1'b0)) u_avail (
      .clk(clk), .rst_n(rst_n),
      .set_i(ev_byte_rx), .clr_i(sw_rhr_rd), .q_o(rx_avail));

   twb_flag_cell #(.SET_WINS(SET_WINS), .RST_VAL(1'b0)) u_ovr (
      .clk(clk), .rst_n(rst_n),
      .set_i(ev_byte_rx & rx_avail), .clr_i(sw_sr_rd), .q_o(rx_overrun));

   p_rx_set_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_byte_rx && !sw_rhr_rd) |=> rx_avail);

   p_overrun_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_byte_rx && rx_avail) |=> rx_overrun);
endmodule

// File: rtl/twb_status_flags.sv
module twb_status_flags
   import twb_status_pkg::*;
#(
   parameter int STATUS_W = 32,
   parameter bit SET_WINS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                slave_mode,
   input  logic                ev_start,
   input  logic                ev_stop,
   input  logic                ev_rs_match,
   input  logic                ev_rs_miss,
   input  logic                ev_byte_rx,
   input  logic                ev_hold_to_shift,
   input  logic                ev_shift_empty,
   input  logic                ev_ack,
   input  logic                ev_nack,
   input  logic                ev_enable,
   input  logic                ev_arb_lost,
   input  logic                lv_slv_rd,
   input  logic                lv_slv_sel,
   input  logic                lv_gen_call,
   input  logic                lv_clk_stretch,
   input  logic                sw_thr_wr,
   input  logic                sw_rhr_rd,
   input  logic                sw_sr_rd,
   output logic [STATUS_W-1:0] status
);
   localparam int PAD_W = STATUS_W - MIN_WORD_W;

   generate
      if (STATUS_W < MIN_WORD_W) begin : g_bad_width
         $error("twb_status_flags: STATUS_W too small for flag layout");
      end
   endgenerate

   logic        xfer_done, tx_free, rx_avail, rx_overrun, nack_seen, arb_lost;
   twb_levels_t lv_q;

   twb_flag_cell #(.SET_WINS(SET_WINS), .RST_VAL(1'b0)) u_nack (
      .clk(clk), .rst_n(rst_n),
      .set_i(ev_nack), .clr_i(sw_sr_rd), .q_o(nack_seen));

   twb_flag_cell #(.SET_WINS(SET_WINS), .RST_VAL(1'b0)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .set_i(ev_arb_lost), .clr_i(sw_sr_rd), .q_o(arb_lost));

   twb_tx_track #(.SET_WINS(SET_WINS)) u_tx (
      .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
      .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_rs_match(ev_rs_match), .ev_rs_miss(ev_rs_miss),
      .ev_hold_to_shift(ev_hold_to_shift), .ev_shift_empty(ev_shift_empty),
      .ev_ack(ev_ack), .ev_nack(ev_nack), .ev_enable(ev_enable),
      .sw_thr_wr(sw_thr_wr), .nack_flag(nack_seen),
      .xfer_done(xfer_done), .tx_free(tx_free));

   twb_rx_track #(.SET_WINS(SET_WINS)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .ev_byte_rx(ev_byte_rx), .sw_rhr_rd(sw_rhr_rd), .sw_sr_rd(sw_sr_rd),
      .rx_avail(rx_avail), .rx_overrun(rx_overrun));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lv_q <= '0;
      else begin
         lv_q.slv_rd      <= lv_slv_rd;
         lv_q.slv_sel     <= lv_slv_sel;
         lv_q.gen_call    <= lv_gen_call;
         lv_q.clk_stretch <= lv_clk_stretch;
      end
   end

   logic [MIN_WORD_W-1:0] low_word;

   always_comb begin
      low_word                  = '0;
      low_word[BIT_XFER_DONE]   = xfer_done;
      low_word[BIT_RX_AVAIL]    = rx_avail;
      low_word[BIT_TX_FREE]     = tx_free;
      low_word[BIT_SLV_RD]      = lv_q.slv_rd;
      low_word[BIT_SLV_SEL]     = lv_q.slv_sel;
      low_word[BIT_GEN_CALL]    = lv_q.gen_call;
      low_word[BIT_RX_OVERRUN]  = rx_overrun;
      low_word[BIT_NACK_SEEN]   = nack_seen;
      low_word[BIT_ARB_LOST]    = arb_lost;
      low_word[BIT_CLK_STRETCH] = lv_q.clk_stretch;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign status = {{PAD_W{1'b0}}, low_word};
      end else begin : g_nopad
         assign status = low_word;
      end
   endgenerate

   p_master_nack_trio_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && ev_nack) |=> (status[BIT_XFER_DONE] && status[BIT_TX_FREE]
                                    && status[BIT_NACK_SEEN]));

   p_sticky_nack_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (nack_seen && !sw_sr_rd) |=> nack_seen);

   p_level_copy_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status[BIT_GEN_CALL] == $past(lv_gen_call)));
endmodule

// File: tb/tb_twb_status_flags.sv
module tb_twb_status_flags;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slave_mode, ev_start, ev_stop, ev_rs_match, ev_rs_miss, ev_byte_rx;
   logic ev_hold_to_shift, ev_shift_empty, ev_ack, ev_nack, ev_enable, ev_arb_lost;
   logic lv_slv_rd, lv_slv_sel, lv_gen_call, lv_clk_stretch;
   logic sw_thr_wr, sw_rhr_rd, sw_sr_rd;
   logic [W-1:0] status;

   int n_run = 0;
   int n_fail = 0;

   // reference state
   logic m_xfer, m_rx, m_free, m_ovr, m_nack, m_arb, m_hold, m_shift;
   logic [3:0] m_lv;

   always #(CLK_PERIOD/2) clk = ~clk;

   twb_status_flags #(.STATUS_W(W), .SET_WINS(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
      .ev_start(ev_start), .ev_stop(ev_stop), .ev_rs_match(ev_rs_match),
      .ev_rs_miss(ev_rs_miss), .ev_byte_rx(ev_byte_rx),
      .ev_hold_to_shift(ev_hold_to_shift), .ev_shift_empty(ev_shift_empty),
      .ev_ack(ev_ack), .ev_nack(ev_nack), .ev_enable(ev_enable),
      .ev_arb_lost(ev_arb_lost), .lv_slv_rd(lv_slv_rd), .lv_slv_sel(lv_slv_sel),
      .lv_gen_call(lv_gen_call), .lv_clk_stretch(lv_clk_stretch),
      .sw_thr_wr(sw_thr_wr), .sw_rhr_rd(sw_rhr_rd), .sw_sr_rd(sw_sr_rd),
      .status(status));

   function automatic logic [W-1:0] exp_word();
      logic [W-1:0] w = '0;
      w[0] = m_xfer; w[1] = m_rx; w[2] = m_free; w[3] = m_lv[0];
      w[4] = m_lv[1]; w[5] = m_lv[2]; w[6] = m_ovr; w[8] = m_nack;
      w[9] = m_arb; w[10] = m_lv[3];
      return w;
   endfunction

   task automatic clear_strobes();
      ev_start = 0; ev_stop = 0; ev_rs_match = 0; ev_rs_miss = 0; ev_byte_rx = 0;
      ev_hold_to_shift = 0; ev_shift_empty = 0; ev_ack = 0; ev_nack = 0;
      ev_enable = 0; ev_arb_lost = 0; sw_thr_wr = 0; sw_rhr_rd = 0; sw_sr_rd = 0;
   endtask

   task automatic model_next();
      logic frz, wr, xs, xc, ts;
      frz = m_free & m_nack;
      wr  = sw_thr_wr & ~frz;
      if (slave_mode) begin
         xs = ev_stop | ev_rs_miss; xc = ev_start | ev_rs_match; ts = ev_ack | ev_nack;
      end else begin
         xs = (ev_stop & ~m_hold & ~m_shift) | ev_nack; xc = ev_start;
         ts = ev_enable | ev_hold_to_shift | ev_nack;
      end
      m_ovr   = (ev_byte_rx & m_rx) ? 1'b1 : sw_sr_rd ? 1'b0 : m_ovr;
      m_rx    = ev_byte_rx ? 1'b1 : sw_rhr_rd ? 1'b0 : m_rx;
      m_xfer  = xs ? 1'b1 : xc ? 1'b0 : m_xfer;
      m_free  = ts ? 1'b1 : wr ? 1'b0 : m_free;
      m_hold  = wr ? 1'b1 : (ev_hold_to_shift | ev_nack) ? 1'b0 : m_hold;
      m_shift = ev_hold_to_shift ? 1'b1 : (ev_shift_empty | ev_nack) ? 1'b0 : m_shift;
      m_nack  = ev_nack ? 1'b1 : sw_sr_rd ? 1'b0 : m_nack;
      m_arb   = ev_arb_lost ? 1'b1 : sw_sr_rd ? 1'b0 : m_arb;
      m_lv    = {lv_clk_stretch, lv_gen_call, lv_slv_sel, lv_slv_rd};
   endtask

   // inputs are set at a falling edge; this moves through one rising edge
   task automatic tick();
      model_next();
      @(posedge clk);
      @(negedge clk);
      clear_strobes();
   endtask

   task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      clear_strobes();
      slave_mode = 0; lv_slv_rd = 0; lv_slv_sel = 0; lv_gen_call = 0; lv_clk_stretch = 0;
      {m_xfer, m_rx, m_free, m_ovr, m_nack, m_arb, m_hold, m_shift} = '0;
      m_lv = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset word", status, '0);
      rst_n = 1;
      @(negedge clk);

      // R6 master transmit-ready
      ev_enable = 1; tick();
      chk("R6 enable sets tx ready", W'(status[2]), W'(1));
      sw_thr_wr = 1; tick();
      chk("R6 write clears tx ready", W'(status[2]), W'(0));
      ev_hold_to_shift = 1; tick();
      chk("R6 move to shifter sets tx ready", W'(status[2]), W'(1));

      // R2 master transfer done
      ev_start = 1; tick();
      chk("R2 start clears done", W'(status[0]), W'(0));
      ev_stop = 1; tick();
      chk("R2 stop with busy shifter keeps done 0", W'(status[0]), W'(0));
      ev_shift_empty = 1; tick();
      ev_stop = 1; tick();
      chk("R2 stop with empty path sets done", W'(status[0]), W'(1));

      // R7 master NACK
      ev_start = 1; tick();
      sw_thr_wr = 1; tick();
      ev_nack = 1; tick();
      chk("R7 nack sets bits 0 2 8", W'({status[8], status[2], status[0]}), W'(3'b111));

      // R9 frozen transmit path
      sw_thr_wr = 1; tick();
      chk("R9 write ignored while frozen", W'(status[2]), W'(1));
      ev_stop = 1; tick();
      chk("R9 no byte became pending", W'(status[0]), W'(1));

      // R10 sticky flags
      chk("R10 nack still set", W'(status[8]), W'(1));
      sw_sr_rd = 1; tick();
      chk("R10 status read clears nack", W'(status[8]), W'(0));
      ev_arb_lost = 1; tick();
      tick();
      chk("R10 arbitration lost sticky", W'(status[9]), W'(1));
      sw_sr_rd = 1; tick();
      chk("R10 status read clears arbitration lost", W'(status[9]), W'(0));

      // R4 / R5 receive path
      ev_byte_rx = 1; tick();
      chk("R4 byte sets rx ready", W'(status[1]), W'(1));
      sw_rhr_rd = 1; tick();
      chk("R4 read clears rx ready", W'(status[1]), W'(0));
      ev_byte_rx = 1; tick();
      chk("R5 single byte no overrun", W'(status[6]), W'(0));
      ev_byte_rx = 1; tick();
      chk("R5 second byte sets overrun", W'(status[6]), W'(1));
      sw_sr_rd = 1; tick();
      chk("R5 status read clears overrun", W'(status[6]), W'(0));

      // R11 same-cycle collisions
      ev_byte_rx = 1; sw_rhr_rd = 1; tick();
      chk("R11 byte wins over read", W'(status[1]), W'(1));
      ev_nack = 1; sw_sr_rd = 1; tick();
      chk("R11 nack wins over status read", W'(status[8]), W'(1));
      sw_sr_rd = 1; tick();

      // R3 slave transfer done
      slave_mode = 1;
      ev_start = 1; tick();
      chk("R3 start clears done", W'(status[0]), W'(0));
      ev_rs_miss = 1; tick();
      chk("R3 foreign repeated start sets done", W'(status[0]), W'(1));
      ev_rs_match = 1; tick();
      chk("R3 own repeated start clears done", W'(status[0]), W'(0));
      ev_stop = 1; tick();
      chk("R3 stop sets done", W'(status[0]), W'(1));

      // R8 slave transmit-ready
      sw_thr_wr = 1; tick();
      chk("R8 write clears tx ready", W'(status[2]), W'(0));
      ev_hold_to_shift = 1; tick();
      ev_shift_empty = 1; tick();
      chk("R8 still 0 before acknowledge", W'(status[2]), W'(0));
      ev_ack = 1; tick();
      chk("R8 ack sets tx ready", W'(status[2]), W'(1));

      // R12 layout of level bits
      lv_slv_rd = 1; lv_gen_call = 1; lv_clk_stretch = 1; lv_slv_sel = 0; tick();
      chk("R12 level bits", W'({status[10], status[5], status[4], status[3]}), W'(4'b1101));
      chk("R12 unused bits zero", status & 32'hFFFF_F880, '0);
      chk("R12 full word", status, exp_word());

      // random phase against reference model
      begin
         int seed = 32'h5EED_0042;
         void'($urandom(seed));
         for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 63) == 0) slave_mode = ~slave_mode;
            ev_start         = ($urandom_range(0, 9) == 0);
            ev_stop          = ($urandom_range(0, 9) == 0);
            ev_rs_match      = ($urandom_range(0, 15) == 0);
            ev_rs_miss       = ($urandom_range(0, 15) == 0);
            ev_byte_rx       = ($urandom_range(0, 5) == 0);
            ev_hold_to_shift = ($urandom_range(0, 7) == 0);
            ev_shift_empty   = ($urandom_range(0, 7) == 0);
            ev_ack           = ($urandom_range(0, 9) == 0);
            ev_nack          = ($urandom_range(0, 19) == 0);
            ev_enable        = ($urandom_range(0, 31) == 0);
            ev_arb_lost      = ($urandom_range(0, 31) == 0);
            sw_thr_wr        = ($urandom_range(0, 5) == 0);
            sw_rhr_rd        = ($urandom_range(0, 5) == 0);
            sw_sr_rd         = ($urandom_range(0, 9) == 0);
            lv_slv_rd        = 1'($urandom_range(0, 1));
            lv_slv_sel       = 1'($urandom_range(0, 1));
            lv_gen_call      = 1'($urandom_range(0, 1));
            lv_clk_stretch   = 1'($urandom_range(0, 1));
            tick();
            chk("R2 R3 R5 R9 R11 random word", status, exp_word());
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule